// File: doc/BRIEF.md
# Round-Key Expansion Engine

This block turns a user key of 16, 24 or 32 bytes into a table of 44 round-key words of 32 bits each. A 20-round, 128-bit block cipher built on data-dependent rotations uses this table. Software or a host block writes the key one 32-bit word at a time into a small key store. It sets a length code and pulses `start`. The engine then fills the table from two fixed constants, one entry per clock. After that it mixes the table with the key words, one step per clock, for 132 steps. Each step uses rotations whose amounts come from the data itself. The table index wraps at 44 and the key index wraps at the number of key words, so the two indices move independently.

When the run completes, `done` rises and stays high. The cipher cores read round keys through a combinational read port addressed by entry number. The mixing writes back into the key store, so the key store holds scrambled words after a run. A key must be loaded again before each new run.

Top module: `rkey_expand`

## Requirements
- R1: While reset is applied and after it is released, with no start seen, `busy` and `done` are both low.
- R2: A write with `key_we` high stores `key_word` at word slot `key_addr`. Key byte k lives in word k/4, bits 8*(k mod 4)+7 down to 8*(k mod 4), so byte 0 sits in bits 7:0 of word 0. The `key_len` code selects the word count: 0 gives 4 words (16 bytes), 1 gives 6 (24), and 2 or 3 give 8 (32). The code is captured on the edge that accepts `start`.
- R3: A `start` sampled high while `busy` is low is accepted. From the next cycle `busy` is high and `done` is low.
- R4: Before mixing, table entry 0 holds 0xB7E15163 and every later entry holds the previous one plus 0x9E3779B9, modulo 2^32.
- R5: `done` rises exactly 176 clock edges after the accepting edge (44 fill plus 132 mixing). `busy` falls on the same edge.
- R6: Mixing runs 132 steps with accumulators X and Y and indices i and j, all starting at zero. Each step sets entry i and X to (entry i + X + Y) rotated left by 3. It then sets key word j and Y to (word j + X + Y) rotated left by the low 5 bits of (X + Y). The final table with 4 key words matches this rule.
- R7: With 6 key words, index j wraps from 5 to 0 while i keeps counting, and the final table matches the rule of R6.
- R8: With 8 key words, and with i wrapping from 43 to 0 after every 44 steps, the final table matches the rule of R6.
- R9: A `start` pulse while `busy` is high is ignored. The run keeps its timing and its result, and a changed `key_len` is not picked up.
- R10: Key-store writes while `busy` is high are ignored and do not disturb the result.
- R11: `done` stays high, and the table keeps its contents, until the next accepted `start`.
- R12: `rk_data` shows table entry `rk_addr` in the same cycle, with no register on the read path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| key_we | input | 1 | Key word write strobe |
| key_addr | input | 3 | Key word slot |
| key_word | input | 32 | Key word, little-endian bytes |
| key_len | input | 2 | Key length code (0: 16 B, 1: 24 B, 2/3: 32 B) |
| start | input | 1 | Start pulse |
| busy | output | 1 | Expansion running |
| done | output | 1 | Round-key table ready |
| rk_addr | input | 6 | Round-key entry to read |
| rk_data | output | 32 | Round-key entry contents |

## Verification
The bench drives `start` for one cycle at a falling edge and samples at later falling edges. `busy` is due one edge after the accepting edge. The bench counts falling edges from there and expects `done` low up to edge 175 and high at edge 176, with `busy` low at the same point. The full 44-entry table is then read through the combinational port, each entry one time unit after its address is set. The reads are compared against a model in the bench that runs the fill and mixing rules directly. Disturbing pulses (a second start, a changed length code, key writes) land at fixed edge counts inside the run, and the 176-edge timing is checked again in those runs.

// File: rtl/ks_pkg.sv
`timescale 1ns/1ps
package ks_pkg;
  parameter int WORD_W = 32;
  parameter logic [WORD_W-1:0] FILL_BASE = 32'hB7E15163;
  parameter logic [WORD_W-1:0] FILL_STEP = 32'h9E3779B9;
  localparam int ROT_W = $clog2(WORD_W);

  typedef enum logic [1:0] {PH_IDLE, PH_FILL, PH_MIX, PH_DONE} phase_t;

  function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] v,
                                              input logic [ROT_W-1:0] s);
    logic [2*WORD_W-1:0] dbl;
    dbl = {v, v} << s;
    return dbl[2*WORD_W-1:WORD_W];
  endfunction

  // length code -> number of key words
  function automatic logic [3:0] code_words(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd4;
      2'd1:    return 4'd6;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/ks_ctrl.sv
`timescale 1ns/1ps
module ks_ctrl import ks_pkg::*; #(
  parameter int TABLE_N = 44,
  parameter int MIX_STEPS = 3 * TABLE_N,
  parameter int KEY_W = 3,
  localparam int IDX_W = $clog2(TABLE_N),
  localparam int CNT_W = $clog2(MIX_STEPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       key_len,
  output logic             busy,
  output logic             done,
  output logic             accept,
  output logic             fill_we,
  output logic             mix_we,
  output logic [IDX_W-1:0] tbl_idx,
  output logic [KEY_W-1:0] key_idx
);
  phase_t           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] ti_q, ti_d;
  logic [KEY_W-1:0] kj_q, kj_d;
  logic [KEY_W:0]   nw_q, nw_d;
  logic             adv;

  assign accept = start && (phase_q == PH_IDLE || phase_q == PH_DONE);
  assign adv    = accept || phase_q == PH_FILL || phase_q == PH_MIX;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    ti_d    = ti_q;
    kj_d    = kj_q;
    nw_d    = nw_q;
    case (phase_q)
      PH_FILL: begin
        if (cnt_q == CNT_W'(TABLE_N - 1)) begin
          phase_d = PH_MIX;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_MIX: begin
        cnt_d = cnt_q + 1'b1;
        ti_d  = (ti_q == IDX_W'(TABLE_N - 1)) ? '0 : ti_q + 1'b1;
        kj_d  = ({1'b0, kj_q} == nw_q - 1'b1) ? '0 : kj_q + 1'b1;
        if (cnt_q == CNT_W'(MIX_STEPS - 1)) phase_d = PH_DONE;
      end
      default: begin
        if (accept) begin
          phase_d = PH_FILL;
          cnt_d   = '0;
          ti_d    = '0;
          kj_d    = '0;
          nw_d    = (KEY_W + 1)'(code_words(key_len));
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      ti_q    <= '0;
      kj_q    <= '0;
      nw_q    <= '0;
    end else if (adv) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      ti_q    <= ti_d;
      kj_q    <= kj_d;
      nw_q    <= nw_d;
    end
  end

  assign busy    = phase_q == PH_FILL || phase_q == PH_MIX;
  assign done    = phase_q == PH_DONE;
  assign fill_we = phase_q == PH_FILL;
  assign mix_we  = phase_q == PH_MIX;
  assign tbl_idx = (phase_q == PH_FILL) ? cnt_q[IDX_W-1:0] : ti_q;
  assign key_idx = kj_q;

  assert_busy_after_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));
  assert_done_excl_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));
  assert_mix_seq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mix_we && cnt_q != CNT_W'(MIX_STEPS - 1)) |=> (mix_we && cnt_q == $past(cnt_q) + 1'b1));
  assert_done_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  assert_i_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mix_we && ti_q == IDX_W'(TABLE_N - 1) && cnt_q != CNT_W'(MIX_STEPS - 1)) |=> ti_q == '0);
endmodule

// File: rtl/ks_table.sv
`timescale 1ns/1ps
module ks_table import ks_pkg::*; #(
  parameter int TABLE_N = 44,
  localparam int IDX_W = $clog2(TABLE_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              fill_we,
  input  logic              mix_we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] mix_data,
  output logic [WORD_W-1:0] cur,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] ent_q [TABLE_N];
  logic [WORD_W-1:0] fill_q, fill_d, wdata;

  always_comb begin
    fill_d = fill_q;
    if (init)         fill_d = FILL_BASE;
    else if (fill_we) fill_d = fill_q + FILL_STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                fill_q <= '0;
    else if (init || fill_we)  fill_q <= fill_d;
  end

  assign wdata = fill_we ? fill_q : mix_data;

  for (genvar e = 0; e < TABLE_N; e++) begin : g_ent
    logic we_e;
    assign we_e = (fill_we || mix_we) && idx == IDX_W'(e);
    always_ff @(posedge clk) begin
      if (we_e) ent_q[e] <= wdata;
    end
  end

  assign cur     = (idx < IDX_W'(TABLE_N)) ? ent_q[idx] : '0;
  assign rd_data = (rd_addr < IDX_W'(TABLE_N)) ? ent_q[rd_addr] : '0;

  assert_fill_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && idx == '0) |-> fill_q == FILL_BASE);
  assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we || mix_we) |-> idx < IDX_W'(TABLE_N));
endmodule

// File: rtl/ks_keyregs.sv
`timescale 1ns/1ps
module ks_keyregs import ks_pkg::*; #(
  parameter int KEY_N = 8,
  localparam int KEY_W = $clog2(KEY_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [KEY_W-1:0]  ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              mix_we,
  input  logic [KEY_W-1:0]  mix_idx,
  input  logic [WORD_W-1:0] mix_data,
  output logic [WORD_W-1:0] cur
);
  logic [WORD_W-1:0] kw_q [KEY_N];

  for (genvar k = 0; k < KEY_N; k++) begin : g_kw
    logic ld_k, mx_k;
    assign ld_k = ld_en && ld_addr == KEY_W'(k);
    assign mx_k = mix_we && mix_idx == KEY_W'(k);
    always_ff @(posedge clk) begin
      if (mx_k)      kw_q[k] <= mix_data;
      else if (ld_k) kw_q[k] <= ld_data;
    end
  end

  assign cur = kw_q[mix_idx];

  assert_no_load_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |-> !mix_we);
endmodule

// File: rtl/rkey_expand.sv
`timescale 1ns/1ps
module rkey_expand import ks_pkg::*; #(
  parameter int TABLE_N = 44,
  parameter int KEY_N = 8,
  localparam int IDX_W = $clog2(TABLE_N),
  localparam int KEY_W = $clog2(KEY_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_we,
  input  logic [KEY_W-1:0]  key_addr,
  input  logic [WORD_W-1:0] key_word,
  input  logic [1:0]        key_len,
  input  logic              start,
  output logic              busy,
  output logic              done,
  input  logic [IDX_W-1:0]  rk_addr,
  output logic [WORD_W-1:0] rk_data
);
  logic              rst_s1_q, rst_s2_q;
  logic              accept, fill_we, mix_we;
  logic [IDX_W-1:0]  tbl_idx;
  logic [KEY_W-1:0]  key_idx;
  logic [WORD_W-1:0] s_cur, l_cur, a_q, b_q, a_d, b_d;
  logic [WORD_W-1:0] sum_ab, a_new, sum_nb, b_new;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s2_q, rst_s1_q} <= 2'b00;
    else        {rst_s2_q, rst_s1_q} <= {rst_s1_q, 1'b1};
  end

  ks_ctrl #(.TABLE_N(TABLE_N), .KEY_W(KEY_W)) ctrl_i (
    .clk(clk), .rst_n(rst_s2_q), .start(start), .key_len(key_len),
    .busy(busy), .done(done), .accept(accept), .fill_we(fill_we),
    .mix_we(mix_we), .tbl_idx(tbl_idx), .key_idx(key_idx));

  ks_table #(.TABLE_N(TABLE_N)) table_i (
    .clk(clk), .rst_n(rst_s2_q), .init(accept), .fill_we(fill_we),
    .mix_we(mix_we), .idx(tbl_idx), .mix_data(a_new), .cur(s_cur),
    .rd_addr(rk_addr), .rd_data(rk_data));

  ks_keyregs #(.KEY_N(KEY_N)) keys_i (
    .clk(clk), .rst_n(rst_s2_q), .ld_en(key_we && !busy), .ld_addr(key_addr),
    .ld_data(key_word), .mix_we(mix_we), .mix_idx(key_idx),
    .mix_data(b_new), .cur(l_cur));

  // one mixing step
  always_comb begin
    sum_ab = s_cur + a_q + b_q;
    a_new  = rotl(sum_ab, ROT_W'(3));
    sum_nb = a_new + b_q;
    b_new  = rotl(l_cur + sum_nb, sum_nb[ROT_W-1:0]);
    a_d    = accept ? '0 : a_new;
    b_d    = accept ? '0 : b_new;
  end

  always_ff @(posedge clk or negedge rst_s2_q) begin
    if (!rst_s2_q) begin
      a_q <= '0;
      b_q <= '0;
    end else if (accept || mix_we) begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assert_acc_clear_R6: assert property (@(posedge clk) disable iff (!rst_s2_q)
    accept |=> (a_q == '0 && b_q == '0));
endmodule

// File: tb/rkey_expand_tb_top.sv
`timescale 1ns/1ps
module rkey_expand_tb_top;
  logic        clk, rst_n, key_we, start;
  logic [2:0]  key_addr;
  logic [31:0] key_word;
  logic [1:0]  key_len;
  logic        busy, done;
  logic [5:0]  rk_addr;
  logic [31:0] rk_data;

  int checks = 0;
  int errors = 0;
  logic [31:0] kw [8];
  logic [31:0] exp_s [44];

  rkey_expand dut_i (.clk(clk), .rst_n(rst_n), .key_we(key_we), .key_addr(key_addr),
    .key_word(key_word), .key_len(key_len), .start(start), .busy(busy), .done(done),
    .rk_addr(rk_addr), .rk_data(rk_data));

  initial clk = 0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] rl(input logic [31:0] x, input int s);
    int r = s % 32;
    if (r == 0) return x;
    return (x << r) | (x >> (32 - r));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic model(input int c);
    logic [31:0] l [8];
    logic [31:0] x = 0, y = 0;
    int i = 0, j = 0;
    exp_s[0] = 32'hB7E15163;
    for (int k = 1; k < 44; k++) exp_s[k] = exp_s[k-1] + 32'h9E3779B9;
    for (int k = 0; k < 8; k++) l[k] = kw[k];
    for (int s = 0; s < 132; s++) begin
      exp_s[i] = rl(exp_s[i] + x + y, 3);
      x = exp_s[i];
      l[j] = rl(l[j] + x + y, int'((x + y) & 32'h1f));
      y = l[j];
      i = (i + 1) % 44;
      j = (j + 1) % c;
    end
  endtask

  task automatic load_key(input int nwords);
    for (int w = 0; w < nwords; w++) begin
      @(negedge clk);
      key_we = 1; key_addr = 3'(w); key_word = kw[w];
    end
    @(negedge clk);
    key_we = 0;
  endtask

  // pack bytes little-endian: byte k -> word k/4, bits 8*(k%4)+:8 (R2)
  task automatic pack_bytes(input int nbytes, input int seed);
    for (int w = 0; w < 8; w++) kw[w] = 32'h0;
    for (int k = 0; k < nbytes; k++)
      kw[k / 4][8 * (k % 4) +: 8] = 8'((k * 37 + seed) & 8'hff);
  endtask

  task automatic run(input string req, input bit poke_start, input bit poke_load);
    int k = 0;
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy && !done, "R3 busy after start", {30'd0, busy, done}, 32'h2);
    while (!done && k < 400) begin
      @(negedge clk);
      k++;
      if (poke_start && k == 10) begin start = 1; key_len = 2'd0; end
      if (poke_start && k == 11) start = 0;
      if (poke_load && k == 60) begin key_we = 1; key_addr = 3'd0; key_word = 32'hDEADBEEF; end
      if (poke_load && k == 61) key_we = 0;
      if (poke_load && k == 150) begin key_we = 1; key_addr = 3'd1; key_word = 32'h12345678; end
      if (poke_load && k == 151) key_we = 0;
    end
    chk(k == 176, {req, " R5 done latency"}, 32'(k), 32'd176);
    chk(!busy, {req, " R5 busy low at done"}, {31'd0, busy}, 32'd0);
    for (int e = 0; e < 44; e++) begin
      rk_addr = 6'(e);
      #1;
      chk(rk_data == exp_s[e], {req, " table entry (fill R4, read R12)"}, rk_data, exp_s[e]);
    end
  endtask

  task automatic t_reset;
    rst_n = 0; start = 0; key_we = 0; key_addr = 0; key_word = 0; key_len = 0; rk_addr = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R1 reset state", {30'd0, busy, done}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!busy && !done, "R1 after release", {30'd0, busy, done}, 0);
  endtask

  task automatic t_key16;
    for (int w = 0; w < 8; w++) kw[w] = 32'h0;
    model(4);
    load_key(4); key_len = 2'd0;
    run("R6 16-byte zero key", 0, 0);
  endtask

  task automatic t_key24;
    pack_bytes(24, 5);
    model(6);
    load_key(6); key_len = 2'd1;
    run("R7 24-byte key", 0, 0);
  endtask

  task automatic t_key32;
    pack_bytes(32, 91);
    model(8);
    load_key(8); key_len = 2'd2;
    run("R8 32-byte key", 0, 0);
  endtask

  task automatic t_start_busy;
    pack_bytes(32, 200);
    model(8);
    load_key(8); key_len = 2'd3;
    run("R9 start during run ignored", 1, 0);
    key_len = 2'd0;
  endtask

  task automatic t_load_busy;
    pack_bytes(16, 77);
    model(4);
    load_key(4); key_len = 2'd0;
    run("R10 key writes during run ignored", 0, 1);
  endtask

  task automatic t_done_hold;
    repeat (20) @(negedge clk);
    chk(done && !busy, "R11 done held", {30'd0, busy, done}, 32'h1);
    rk_addr = 6'd43;
    #1;
    chk(rk_data == exp_s[43], "R11 table stable after done", rk_data, exp_s[43]);
    rk_addr = 6'd7;
    #1;
    chk(rk_data == exp_s[7], "R12 same-cycle read", rk_data, exp_s[7]);
  endtask

  initial begin
    t_reset();
    t_key16();
    t_key24();
    t_key32();
    t_start_busy();
    t_load_busy();
    t_done_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule